// File: doc/BRIEF.md
# AC Loss Resume Policy Controller

This block decides whether a system turns itself back on once mains power returns after an outage. It watches three power-good flags from external comparators: supply good, main rail good and standby rail good. When any of them drops, it records whether the host was running at that moment. The record is taken from a host-active input, where 1 means the host was running and 0 means it was in a sleep or soft-off state.

When all three flags are high again and stay high for a programmable settle time, the block applies a 2-bit resume policy. It then either issues a fixed-length power-on request pulse or stays quiet. The policy can force the system on, force it off, or follow the recorded host state. The good flags pass through a two-stage synchronizer before any logic uses them.

Leaving reset counts as a power-loss event with a recorded host state of 0. A cold start therefore follows the same settle-and-decide path as a real outage.

Top module: `acl_resume_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, `pwr_on_req_o` is 0.
- R2: A drop of any single good flag (`supply_ok_i`, `main_rail_ok_i` or `stby_rail_ok_i`) counts as a power-loss event. So does any combination of drops.
- R3: On a power-loss event the block records `host_active_i` as it stands on the third clock edge after the drop (two synchronizer stages plus one). Later changes of `host_active_i` have no effect on that resume decision.
- R4: Only the first loss after a decision records the host state. A second drop before the decision, such as a flag bouncing during the settle time, does not overwrite the record.
- R5: Policy code 2'b01 (force on) produces a power-on pulse whatever host state was recorded.
- R6: Policy codes 2'b00 (force off) and 2'b11 (reserved) never produce a power-on pulse.
- R7: Policy code 2'b10 (follow host) produces a pulse exactly when the recorded host state is 1.
- R8: `pwr_on_req_o` rises SYNC_STAGES + 1 + SETTLE_CYCLES clock edges after all three good flags go high. The settle count is taken from the first edge on which all three are seen high. A drop during the settle time restarts the full count.
- R9: A pulse lasts exactly PULSE_CYCLES cycles, and each resume gives at most one pulse.
- R10: A loss that arrives during the pulse ends it SYNC_STAGES + 1 edges after the drop. It also records a new host state.
- R11: Release of reset is treated as a power loss with a recorded host state of 0. Under 2'b10 a cold start gives no pulse, and under 2'b01 it gives one.
- R12: The policy is read on the edge where the settle count completes. Changing it while power is still down has no effect on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| supply_ok_i | input | 1 | Supply good flag, asynchronous |
| main_rail_ok_i | input | 1 | Main rail above threshold, asynchronous |
| stby_rail_ok_i | input | 1 | Standby rail above threshold, asynchronous |
| host_active_i | input | 1 | 1 = host running, 0 = host asleep or off |
| policy_i | input | 2 | Resume policy: 00 off, 01 on, 10 follow host, 11 treated as off |
| pwr_on_req_o | output | 1 | Power-on request pulse |

## Verification
The hardest situation to reach is a recorded host state that must survive a second loss. This happens when a flag recovers briefly, drops again before the settle count finishes, and the host input has changed in between. The bench builds this case on purpose: it drops a rail with the host running, clears the host input, and restores the rail for fewer cycles than the settle time before dropping it again. It then checks that the follow-host policy still pulses, and that the pulse lands a full settle time after the final recovery. Randomized rounds mix the policy codes, the host level at the drop, which flags fail, and host changes made after the record was taken.

// File: rtl/acl_pkg.sv
package acl_pkg;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_LOST   = 2'd1,
        ST_SETTLE = 2'd2,
        ST_PULSE  = 2'd3
    } rs_state_e;

    typedef enum logic [1:0] {
        POL_OFF  = 2'b00,
        POL_ON   = 2'b01,
        POL_KEEP = 2'b10,
        POL_RSVD = 2'b11
    } rs_policy_e;

endpackage

// File: rtl/acl_sync.sv
module acl_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    // Stage 0 samples the asynchronous flags; later stages settle metastability.
    // Reset value 0 means "not good", so a cold start looks like an outage.
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= async_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/acl_policy_decode.sv
module acl_policy_decode
    import acl_pkg::*;
(
    input  logic [1:0] policy_i,
    input  logic       latched_i,
    output logic       resume_on_o
);

    always_comb begin
        unique case (rs_policy_e'(policy_i))
            POL_ON:   resume_on_o = 1'b1;
            POL_KEEP: resume_on_o = latched_i;
            default:  resume_on_o = 1'b0;   // force off and reserved code
        endcase
    end

endmodule

// File: rtl/acl_resume_fsm.sv
module acl_resume_fsm
    import acl_pkg::*;
#(
    parameter int unsigned SETTLE_CYCLES = 16,
    parameter int unsigned PULSE_CYCLES  = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       good_i,
    input  logic       host_active_i,
    input  logic [1:0] policy_i,
    input  logic       resume_on_i,
    output logic       latched_o,
    output logic       req_o
);

    localparam int unsigned MAXC = (SETTLE_CYCLES > PULSE_CYCLES) ? SETTLE_CYCLES : PULSE_CYCLES;
    localparam int unsigned CW   = $clog2(MAXC) + 1;
    localparam logic [CW-1:0] SETTLE_LAST = CW'(SETTLE_CYCLES - 1);
    localparam logic [CW-1:0] PULSE_LAST  = CW'(PULSE_CYCLES - 1);

    typedef struct packed {
        rs_state_e     state;
        logic          latched;
        logic [CW-1:0] cnt;
        logic          req;
    } rs_regs_t;

    localparam rs_regs_t RESET_VAL = '{state: ST_LOST, latched: 1'b0, cnt: '0, req: 1'b0};

    rs_regs_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_RUN: begin
                if (!good_i) begin
                    r_d.state   = ST_LOST;
                    r_d.latched = host_active_i;
                end
            end
            ST_LOST: begin
                if (good_i) begin
                    r_d.state = ST_SETTLE;
                    r_d.cnt   = '0;
                end
            end
            ST_SETTLE: begin
                if (!good_i) begin
                    r_d.state = ST_LOST;
                end else if (r_q.cnt == SETTLE_LAST) begin
                    r_d.cnt = '0;
                    if (resume_on_i) begin
                        r_d.state = ST_PULSE;
                        r_d.req   = 1'b1;
                    end else begin
                        r_d.state = ST_RUN;
                    end
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_PULSE: begin
                if (!good_i) begin
                    r_d.state   = ST_LOST;
                    r_d.latched = host_active_i;
                    r_d.req     = 1'b0;
                end else if (r_q.cnt == PULSE_LAST) begin
                    r_d.state = ST_RUN;
                    r_d.req   = 1'b0;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            default: r_d = RESET_VAL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= RESET_VAL;
        else        r_q <= r_d;
    end

    assign latched_o = r_q.latched;
    assign req_o     = r_q.req;

    // A pulse only starts after a cycle in which power was seen good.
    AST_RISE_NEEDS_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_o) |-> $past(good_i)) else $error("rise without good");  // R8

    // Forcing off or the reserved code never lets a pulse start.
    AST_OFF_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_o) |-> ($past(policy_i) == 2'b01 || $past(policy_i) == 2'b10)) else $error("pulse under off policy");  // R6

    // While waiting for or settling after a loss, the record never changes.
    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(r_q.state) == ST_LOST || $past(r_q.state) == ST_SETTLE) |-> $stable(r_q.latched)) else $error("record overwritten");  // R4

    // A fresh loss while running records the host level seen on that edge.
    AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(r_q.state) == ST_RUN && !$past(good_i)) |-> (r_q.latched == $past(host_active_i))) else $error("bad capture");  // R3

    // A pulse ends either at full length or because power dropped.
    AST_PULSE_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_o) |-> ($past(r_q.cnt) == PULSE_LAST || !$past(good_i))) else $error("pulse cut short");  // R9

endmodule

// File: rtl/acl_resume_ctrl.sv
module acl_resume_ctrl
    import acl_pkg::*;
#(
    parameter int unsigned SYNC_STAGES   = 2,
    parameter int unsigned SETTLE_CYCLES = 16,
    parameter int unsigned PULSE_CYCLES  = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       supply_ok_i,
    input  logic       main_rail_ok_i,
    input  logic       stby_rail_ok_i,
    input  logic       host_active_i,
    input  logic [1:0] policy_i,
    output logic       pwr_on_req_o
);

    localparam int unsigned NFLAGS = 3;

    logic [NFLAGS-1:0] flags_s;
    logic              all_good_s;
    logic              latched;
    logic              resume_on;

    acl_sync #(.WIDTH(NFLAGS), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({stby_rail_ok_i, main_rail_ok_i, supply_ok_i}),
        .sync_o  (flags_s)
    );

    // Any single flag low is a loss (R2).
    assign all_good_s = &flags_s;

    acl_policy_decode u_decode (
        .policy_i    (policy_i),
        .latched_i   (latched),
        .resume_on_o (resume_on)
    );

    acl_resume_fsm #(.SETTLE_CYCLES(SETTLE_CYCLES), .PULSE_CYCLES(PULSE_CYCLES)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .good_i        (all_good_s),
        .host_active_i (host_active_i),
        .policy_i      (policy_i),
        .resume_on_i   (resume_on),
        .latched_o     (latched),
        .req_o         (pwr_on_req_o)
    );

endmodule

// File: tb/acl_resume_ctrl_tb.sv
module acl_resume_ctrl_tb;

    localparam int SYNC = 2;
    localparam int SET  = 16;
    localparam int PUL  = 8;
    localparam int RISE = SYNC + 1 + SET;
    localparam int WIN  = RISE + PUL + 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sup = 1'b1, mainr = 1'b1, stby = 1'b1;
    logic       host = 1'b0;
    logic [1:0] pol = 2'b00;
    logic       req;

    int vectors = 0;
    int errors  = 0;

    always #2 clk = ~clk;

    acl_resume_ctrl #(.SYNC_STAGES(SYNC), .SETTLE_CYCLES(SET), .PULSE_CYCLES(PUL)) u_dut (
        .clk(clk), .rst_n(rst_n), .supply_ok_i(sup), .main_rail_ok_i(mainr),
        .stby_rail_ok_i(stby), .host_active_i(host), .policy_i(pol), .pwr_on_req_o(req)
    );

    function automatic bit exp_on(input logic [1:0] p, input logic h);
        case (p)
            2'b01:   return 1'b1;
            2'b10:   return h;
            default: return 1'b0;
        endcase
    endfunction

    task automatic chk(input string rq, input int act, input int exp, input string what);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic set_rails(input logic [2:0] down);
        sup = ~down[0]; mainr = ~down[1]; stby = ~down[2];
    endtask

    // Called at a negedge right after all rails go good; returns rise edge index and width.
    task automatic measure(output int rise_at, output int width, output int pulses);
        logic prev = 1'b0;
        rise_at = -1; width = 0; pulses = 0;
        for (int i = 1; i <= WIN; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (req && rise_at < 0) rise_at = i;
            if (req) width++;
            if (req && !prev) pulses++;
            prev = req;
        end
    endtask

    task automatic check_resume(input string rq, input bit on);
        int ra, w, np;
        measure(ra, w, np);
        chk(rq, np, on ? 1 : 0, "pulse count");
        if (on) begin
            chk("R8", ra, RISE, "rise edge");
            chk("R9", w, PUL, "pulse width");
        end
    endtask

    // Loss with host level h held across the capture edge, then host changed.
    task automatic loss_event(input logic [2:0] down, input logic h, input logic h_after);
        host = h;
        set_rails(down);
        wait_cyc(SYNC + 2);
        host = h_after;
        wait_cyc(3);
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL R1 watchdog: actual hang expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        int ra, w, np;
        void'($urandom(32'h5eed_1234));

        // R1 and R11: cold start under follow-host policy stays off.
        pol = 2'b10;
        wait_cyc(3);
        chk("R1", req, 0, "req in reset");
        rst_n = 1'b1;
        chk("R1", req, 0, "req after release");
        check_resume("R11", 1'b0);

        // R11: cold start under force-on pulses.
        rst_n = 1'b0; pol = 2'b01;
        wait_cyc(2);
        rst_n = 1'b1;
        check_resume("R11", 1'b1);

        // R2, R5: each single flag and force on.
        for (int b = 0; b < 3; b++) begin
            loss_event(3'(1 << b), 1'b0, 1'b0);
            chk("R2", req, 0, "no req while down");
            set_rails(3'b000);
            check_resume("R2", 1'b1);
        end

        // R6: force off and reserved with host running.
        pol = 2'b00;
        loss_event(3'b010, 1'b1, 1'b1);
        set_rails(3'b000);
        check_resume("R6", 1'b0);
        pol = 2'b11;
        loss_event(3'b100, 1'b1, 1'b1);
        set_rails(3'b000);
        check_resume("R6", 1'b0);

        // R3, R7: recorded host 1 then host cleared -> still pulses.
        pol = 2'b10;
        loss_event(3'b001, 1'b1, 1'b0);
        set_rails(3'b000);
        check_resume("R3", 1'b1);
        // R7: recorded 0 then host set -> no pulse.
        loss_event(3'b001, 1'b0, 1'b1);
        set_rails(3'b000);
        check_resume("R7", 1'b0);

        // R4, R8: bounce during settle with host changed; record kept, count restarts.
        loss_event(3'b010, 1'b1, 1'b0);
        set_rails(3'b000);
        wait_cyc(SYNC + 1 + SET / 2);
        chk("R4", req, 0, "no req mid settle");
        host = 1'b0;
        loss_event(3'b010, 1'b0, 1'b0);
        set_rails(3'b000);
        check_resume("R4", 1'b1);

        // R12: policy changed while down, value at decision wins.
        pol = 2'b00;
        loss_event(3'b100, 1'b1, 1'b1);
        pol = 2'b01;
        wait_cyc(2);
        pol = 2'b00;
        set_rails(3'b000);
        check_resume("R12", 1'b0);

        // R10: loss during the pulse ends it and records anew.
        pol = 2'b01;
        loss_event(3'b001, 1'b0, 1'b0);
        set_rails(3'b000);
        wait_cyc(RISE);
        chk("R10", req, 1, "pulse started");
        host = 1'b1;
        set_rails(3'b001);
        wait_cyc(SYNC);
        chk("R10", req, 1, "pulse still on before sync");
        wait_cyc(1);
        chk("R10", req, 0, "pulse ended by loss");
        host = 1'b0;
        wait_cyc(4);
        pol = 2'b10;
        set_rails(3'b000);
        check_resume("R10", 1'b1);

        // Random rounds.
        for (int n = 0; n < 40; n++) begin
            logic [1:0] p;
            logic [2:0] m;
            logic h, h2;
            p  = 2'($urandom_range(0, 3));
            m  = 3'($urandom_range(1, 7));
            h  = 1'($urandom_range(0, 1));
            h2 = 1'($urandom_range(0, 1));
            pol = p;
            loss_event(m, h, h2);
            set_rails(3'b000);
            measure(ra, w, np);
            chk("R7", np, exp_on(p, h) ? 1 : 0, "random pulse count");
            if (exp_on(p, h)) begin
                chk("R8", ra, RISE, "random rise edge");
                chk("R9", w, PUL, "random width");
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule